// File: doc/BRIEF.md
# Decade Time Base with Gate and Prescaler Outputs

This block is the time base of a universal counter. One of three incoming level signals is picked: a reference oscillator or either of two measurement channels. The block registers it twice, which also brings it into the system clock domain, and turns each of its rising edges into a single-cycle count pulse. Those pulses drive a chain of eight free-running decimal digits. The count pulse and the carry out of each digit together form nine taps, and a pulse on tap k comes once every 10^k input edges.

A 4-bit scale code picks one tap. Two outputs come from the same chain at the same time. A shaping register turns the picked tap into a divide-by-N pulse stream for totalizing. A gate sequencer makes a measurement window for frequency and interval work. After an arm request, the window opens on the next pulse of the picked tap and closes on the pulse after it, so it spans exactly N input edges. A completion strobe marks the close. Downstream logic decides which of the two outputs to use.

Top module: `decade_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven low after that edge, the digit chain is cleared to zero and the gate sequencer returns to idle.
- R2: `src_sel` picks the counted signal: 0 is `ref_in`, 1 is `cha_in`, 2 is `chb_in`, and 3 picks nothing, so no edges are counted.
- R3: Only rising edges of the picked signal are counted. Suppose the picked signal is first sampled high at clock edge k. If that edge is the one that produces a scaled pulse, `scaled_out` is high during the cycle after edge k+1, and only in that cycle.
- R4: The code c gives N = 10^c. `scaled_out` pulses on every N-th counted edge, counting from reset. With c = 0 it pulses on every edge.
- R5: Code values from 9 to 15 behave as code 8, which means N = 10^8.
- R6: An `arm` pulse seen while idle starts a gate. `gate_out` rises in the cycle in which a pulse on the gate's selected tap appears, and it falls on the next such pulse. The gate therefore spans exactly N counted edges. With a steady input period of P clocks it is high for N*P cycles.
- R7: `gate_done` is high for exactly one cycle, which is the first cycle with `gate_out` low after a gate.
- R8: An `arm` pulse that arrives while a gate is waiting to open or is already open has no effect.
- R9: The gate uses the code captured at the arm pulse. `scaled_out` always follows the code currently on `tb_code`.
- R10: The digit chain runs without stopping, so the gate edges line up with multiples of N counted edges since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Counted-source select |
| ref_in | input | 1 | Reference oscillator level |
| cha_in | input | 1 | Channel one level |
| chb_in | input | 1 | Channel two level |
| tb_code | input | 4 | Decade scale code |
| arm | input | 1 | Request one measurement gate |
| gate_out | output | 1 | Measurement gate |
| gate_done | output | 1 | One-cycle strobe at gate close |
| scaled_out | output | 1 | Divide-by-N pulse stream |

## Verification
A steady reference with a period of four clocks is run under codes 0, 1 and 2, and the gate width is measured each time. These runs show whether the right tap was picked, because each decade multiplies the width by ten. An irregular channel waveform with long and short highs and varying gaps shows that the block counts edges and not high cycles. A source change mid-run, the empty source, and an oversized code test the multiplexer and the clamp. Arm pulses sent during an open gate, and code changes made after arming, separate the captured code from the live one.

// File: rtl/decade_timebase_pkg.sv
package decade_timebase_pkg;

    localparam int unsigned CODE_W = 4;

    typedef enum logic [1:0] {
        SRC_REF  = 2'd0,
        SRC_CHA  = 2'd1,
        SRC_CHB  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_WAIT  = 2'd1,
        GS_OPEN  = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic gate;
        logic done;
    } gate_flags_t;

    function automatic logic [CODE_W-1:0] clamp_code(
        input logic [CODE_W-1:0] c,
        input int unsigned       top
    );
        logic [CODE_W-1:0] lim;
        lim = CODE_W'(top);
        return (c > lim) ? lim : c;
    endfunction

endpackage

// File: rtl/tb_input_stage.sv
module tb_input_stage
    import decade_timebase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       ref_in,
    input  logic       cha_in,
    input  logic       chb_in,
    output logic       edge_pulse
);
    logic picked;
    logic stage1_q;
    logic stage2_q;

    always_comb begin
        case (src_e'(src_sel))
            SRC_REF:  picked = ref_in;
            SRC_CHA:  picked = cha_in;
            SRC_CHB:  picked = chb_in;
            default:  picked = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= picked;
            stage2_q <= stage1_q;
        end
    end

    assign edge_pulse = stage1_q & ~stage2_q;
endmodule

// File: rtl/decade_digit.sv
module decade_digit (
    input  logic       clk,
    input  logic       rst,
    input  logic       cin,
    output logic [3:0] digit,
    output logic       cout
);
    logic [3:0] digit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            digit_q <= 4'd0;
        end else if (cin) begin
            digit_q <= (digit_q == 4'd9) ? 4'd0 : digit_q + 4'd1;
        end
    end

    assign digit = digit_q;
    assign cout  = cin & (digit_q == 4'd9);
endmodule

// File: rtl/decade_chain.sv
module decade_chain #(
    parameter int unsigned DECADES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    edge_pulse,
    output logic [DECADES:0]        taps,
    output logic [DECADES-1:0][3:0] digits
);
    logic [DECADES:0] carry;

    assign carry[0] = edge_pulse;

    for (genvar g = 0; g < DECADES; g++) begin : g_dec
        decade_digit u_digit (
            .clk   (clk),
            .rst   (rst),
            .cin   (carry[g]),
            .digit (digits[g]),
            .cout  (carry[g+1])
        );
    end

    assign taps = carry;
endmodule

// File: rtl/tb_gate_ctrl.sv
module tb_gate_ctrl
    import decade_timebase_pkg::*;
#(
    parameter int unsigned DECADES = 8,
    localparam int unsigned SEL_W  = $clog2(DECADES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [SEL_W-1:0] code_sel,
    input  logic [DECADES:0] taps,
    output gate_flags_t      flags,
    output logic             waiting
);
    gate_st_e         state_q;
    logic [SEL_W-1:0] code_l;
    gate_flags_t      flags_q;
    logic             tap_hit;

    assign tap_hit = taps[code_l];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_IDLE;
            code_l  <= '0;
            flags_q <= '0;
        end else begin
            flags_q.done <= 1'b0;
            case (state_q)
                GS_IDLE: begin
                    if (arm) begin
                        state_q <= GS_WAIT;
                        code_l  <= code_sel;
                    end
                end
                GS_WAIT: begin
                    if (tap_hit) begin
                        state_q      <= GS_OPEN;
                        flags_q.gate <= 1'b1;
                    end
                end
                GS_OPEN: begin
                    if (tap_hit) begin
                        state_q      <= GS_IDLE;
                        flags_q.gate <= 1'b0;
                        flags_q.done <= 1'b1;
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    assign flags   = flags_q;
    assign waiting = (state_q == GS_WAIT);
endmodule

// File: rtl/decade_timebase.sv
module decade_timebase
    import decade_timebase_pkg::*;
#(
    parameter int unsigned DECADES = 8,
    localparam int unsigned SEL_W  = $clog2(DECADES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] src_sel,
    input  logic       ref_in,
    input  logic       cha_in,
    input  logic       chb_in,
    input  logic [3:0] tb_code,
    input  logic       arm,
    output logic       gate_out,
    output logic       gate_done,
    output logic       scaled_out
);
    logic                    edge_pulse;
    logic [DECADES:0]        taps;
    logic [DECADES-1:0][3:0] digits;
    logic [SEL_W-1:0]        code_sel;
    logic                    shaped_q;
    logic                    waiting;
    gate_flags_t             flags;

    assign code_sel = SEL_W'(clamp_code(tb_code, DECADES));

    tb_input_stage u_in (
        .clk        (clk),
        .rst        (rst),
        .src_sel    (src_sel),
        .ref_in     (ref_in),
        .cha_in     (cha_in),
        .chb_in     (chb_in),
        .edge_pulse (edge_pulse)
    );

    decade_chain #(.DECADES(DECADES)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .edge_pulse (edge_pulse),
        .taps       (taps),
        .digits     (digits)
    );

    tb_gate_ctrl #(.DECADES(DECADES)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .code_sel (code_sel),
        .taps     (taps),
        .flags    (flags),
        .waiting  (waiting)
    );

    always_ff @(posedge clk) begin
        if (rst) shaped_q <= 1'b0;
        else     shaped_q <= taps[code_sel];
    end

    assign scaled_out = shaped_q;
    assign gate_out   = flags.gate;
    assign gate_done  = flags.done;
endmodule

// File: rtl/decade_timebase_chk.sv
module decade_timebase_chk #(
    parameter int unsigned DECADES = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [1:0]              src_sel,
    input logic                    gate_out,
    input logic                    gate_done,
    input logic                    edge_pulse,
    input logic                    waiting,
    input logic [DECADES-1:0][3:0] digits
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        gate_done |=> !gate_done); // R7
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_out) |-> gate_done); // R7
    AST_DONE_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
        gate_done |-> $fell(gate_out)); // R7
    AST_OPEN_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_out) |-> $past(waiting)); // R6
    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ($past(src_sel) == 2'd3) |-> !edge_pulse); // R2

    for (genvar g = 0; g < DECADES; g++) begin : g_rng
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            digits[g] <= 4'd9); // R10
    end
endmodule

bind decade_timebase decade_timebase_chk #(.DECADES(DECADES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_sel    (src_sel),
    .gate_out   (gate_out),
    .gate_done  (gate_done),
    .edge_pulse (edge_pulse),
    .waiting    (waiting),
    .digits     (digits)
);

// File: tb/decade_timebase_tb.sv
module decade_timebase_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd0;
    logic       ref_in = 1'b0;
    logic       cha_in = 1'b0;
    logic       chb_in = 1'b0;
    logic [3:0] tb_code = 4'd0;
    logic       arm = 1'b0;
    logic       gate_out, gate_done, scaled_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int ref_half = 2;
    int ref_cnt = 0;
    bit started = 0;
    bit finished = 0;
    int scaled_seen = 0;

    always #5 clk = ~clk;

    decade_timebase u_dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .ref_in(ref_in),
        .cha_in(cha_in), .chb_in(chb_in), .tb_code(tb_code), .arm(arm),
        .gate_out(gate_out), .gate_done(gate_done), .scaled_out(scaled_out)
    );

    // reference model state
    bit m_in1, m_in2;
    longint m_cnt;
    int m_state;          // 0 idle, 1 waiting, 2 open
    int m_code_l;
    bit exp_gate, exp_done, exp_scaled;

    function automatic longint p10(input int k);
        longint v = 1;
        for (int i = 0; i < k; i++) v = v * 10;
        return v;
    endfunction

    function automatic int clampc(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    always @(posedge clk) begin
        bit e, t_live, t_gate, pick;
        started = 1;
        if (rst) begin
            m_in1 = 0; m_in2 = 0; m_cnt = 0; m_state = 0; m_code_l = 0;
            exp_gate = 0; exp_done = 0; exp_scaled = 0;
        end else begin
            e = m_in1 && !m_in2;
            t_live = e && (((m_cnt + 1) % p10(clampc(tb_code))) == 0);
            t_gate = e && (((m_cnt + 1) % p10(m_code_l)) == 0);
            exp_scaled = t_live;
            exp_done = 0;
            if (m_state == 0) begin
                if (arm) begin m_state = 1; m_code_l = clampc(tb_code); end
            end else if (m_state == 1) begin
                if (t_gate) begin m_state = 2; exp_gate = 1; end
            end else begin
                if (t_gate) begin m_state = 0; exp_gate = 0; exp_done = 1; end
            end
            if (e) m_cnt = (m_cnt + 1) % 100000000;
            case (src_sel)
                2'd0: pick = ref_in;
                2'd1: pick = cha_in;
                2'd2: pick = chb_in;
                default: pick = 0;
            endcase
            m_in2 = m_in1;
            m_in1 = pick;
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(scaled_out === exp_scaled, "R4 scaled_out", int'(scaled_out), int'(exp_scaled));
            chk(gate_out === exp_gate, "R6 gate_out", int'(gate_out), int'(exp_gate));
            chk(gate_done === exp_done, "R7 gate_done", int'(gate_done), int'(exp_done));
            if (scaled_out === 1'b1) scaled_seen++;
        end
    end

    // reference oscillator, cycles stay at P = 2*ref_half
    always @(negedge clk) begin
        ref_cnt++;
        if (ref_cnt >= ref_half) begin ref_cnt = 0; ref_in = ~ref_in; end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic measure_gate(input int exp_w, input string req);
        int w = 0;
        int t = 0;
        while (gate_out !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
        while (gate_out === 1'b1 && w < 20000) begin @(negedge clk); w++; end
        chk(w == exp_w, req, w, exp_w);
    endtask

    initial begin
        wait_cyc(3);
        chk(gate_out === 1'b0 && gate_done === 1'b0 && scaled_out === 1'b0,
            "R1 reset outputs", int'(gate_out) + int'(scaled_out), 0);
        @(negedge clk); rst = 1'b0;

        // R3 / R4: code 0 passes every edge, P = 4
        tb_code = 4'd0;
        scaled_seen = 0;
        wait_cyc(40);
        chk(scaled_seen >= 9 && scaled_seen <= 11, "R3 edge rate code0", scaled_seen, 10);

        // R6 R10: gate widths per decade
        pulse_arm(); measure_gate(4, "R6 gate code0");
        tb_code = 4'd1; pulse_arm(); measure_gate(40, "R6 gate code1");
        tb_code = 4'd2; pulse_arm(); measure_gate(400, "R10 gate code2");

        // R8: arm while waiting and open is ignored
        tb_code = 4'd1; pulse_arm();
        pulse_arm(); pulse_arm();
        measure_gate(40, "R8 repeat arm");
        chk(gate_out === 1'b0, "R8 no retrigger", int'(gate_out), 0);
        wait_cyc(60);
        chk(gate_out === 1'b0, "R8 stays idle", int'(gate_out), 0);

        // R9: gate keeps captured code, scaled follows live code
        tb_code = 4'd1; pulse_arm();
        tb_code = 4'd2;
        measure_gate(40, "R9 latched code");
        scaled_seen = 0;
        wait_cyc(800);
        chk(scaled_seen == 2, "R9 live code", scaled_seen, 2);

        // R2 R3: channel one with irregular pulses, code 0
        tb_code = 4'd0; src_sel = 2'd1;
        wait_cyc(4);
        scaled_seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); cha_in = 1'b1;
            wait_cyc(1 + (i % 4));
            cha_in = 1'b0;
            wait_cyc(2 + (i % 3));
        end
        wait_cyc(5);
        chk(scaled_seen == 12, "R3 edges not levels", scaled_seen, 12);

        // R2: empty source
        src_sel = 2'd3;
        wait_cyc(4);
        scaled_seen = 0;
        wait_cyc(100);
        chk(scaled_seen == 0, "R2 no source", scaled_seen, 0);

        // R2: channel two
        src_sel = 2'd2;
        wait_cyc(3);
        scaled_seen = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); chb_in = 1'b1;
            wait_cyc(3);
            chb_in = 1'b0;
            wait_cyc(2);
        end
        wait_cyc(5);
        chk(scaled_seen == 7, "R2 channel two", scaled_seen, 7);

        // R5: oversized code clamps to 8
        src_sel = 2'd0; tb_code = 4'd12;
        scaled_seen = 0;
        wait_cyc(400);
        chk(scaled_seen == 0, "R5 clamp", scaled_seen, 0);
        tb_code = 4'd0;
        wait_cyc(20);

        // R1: reset mid-activity
        pulse_arm();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(gate_out === 1'b0 && scaled_out === 1'b0, "R1 reset clears",
            int'(gate_out) + int'(scaled_out), 0);
        @(negedge clk); rst = 1'b0;
        tb_code = 4'd1; pulse_arm(); measure_gate(40, "R1 R10 after reset");
        wait_cyc(10);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule